// File: doc/BRIEF.md
# Flash Operation Status Poller

This block runs on the host side of a NOR flash interface and works out whether an embedded program or erase has finished. After a one-cycle start pulse it reads the status byte from one memory address again and again through a simple read port. It applies one of two completion rules to each returned byte. In data-polling mode, bit 7 of the byte is compared with bit 7 of the data the host expects to find. In toggle mode, bit 6 is compared with bit 6 of the previous read. The block finishes with a two-bit result code that stays on its output until the next accepted start.

The status byte can also report that the operation exceeded its internal time limit (bit 5). That bit can rise in the same read in which the completion bit settles, so one reading of it does not prove failure. The block reads again and declares failure only if the completion rule still shows the operation as busy. In toggle mode it can also tell a sector whose erase is suspended apart from one that is still erasing. Bit 6 holds still in both a suspended sector and a finished one, but bit 2 keeps toggling only in the suspended sector. The block also shows bit 3, which tells the host that the erase acceptance window has closed. For a chip erase the host sets the expected data to FFh and polls any address in a sector that is not protected.

The timing of each bus read is outside this block. The external read port holds the returned byte valid in the cycle in which it raises its acknowledge.

Top module: `flash_status_poller`

## Requirements
- R1: After reset, `rd_req_o`, `busy_o`, `done_o`, `suspended_o` and `erase_begun_o` are low and `result_o` is 00 (busy code).
- R2: A start pulse while idle latches the mode, the expected data and the address. `busy_o` and `rd_req_o` stay high until the operation finishes, and every read is issued to the latched address. `result_o` reads 00 while busy.
- R3: In data-polling mode (`mode_i`=0), a read whose bit 7 equals bit 7 of the expected data finishes the operation with result 01 (pass).
- R4: In toggle mode (`mode_i`=1), a read whose bit 6 equals bit 6 of the previous read of the same operation finishes with result 01. The first read of an operation never finishes it by this rule.
- R5: A busy read with bit 5 set causes a re-check. In data-polling mode the re-check is one further read, judged against bit 7. In toggle mode it is two further reads, whose bit 6 values are compared. The result is 10 (fail) only if the re-check still shows busy; otherwise it is 01.
- R6: If MAX_POLLS reads of the normal polling phase all show busy with bit 5 clear, the operation finishes with result 11 (timeout) after exactly MAX_POLLS reads.
- R7: `suspended_o` is set when an operation passes in toggle mode and bit 2 differed between the two reads that were compared. It is low in every other case.
- R8: `erase_begun_o` equals bit 3 of the most recently returned status byte and is cleared when a start is accepted.
- R9: Each operation produces exactly one cycle of `done_o`. At that point `rd_req_o` and `busy_o` are low. The result code is then held unchanged until the next accepted start.
- R10: A start pulse while busy is ignored. The mode, address and outcome of the running operation are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for a new status check |
| mode_i | input | 1 | 0 = data polling, 1 = toggle |
| exp_i | input | 8 | Expected data byte (bit 7 is used) |
| addr_i | input | ADDR_W | Address to poll |
| rd_req_o | output | 1 | Read request, held while a read is wanted |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ack_i | input | 1 | Read port acknowledge, one cycle per read |
| rd_data_i | input | 8 | Status byte, valid with `rd_ack_i` |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when a result is written |
| result_o | output | 2 | 00 busy, 01 pass, 10 fail, 11 timeout |
| suspended_o | output | 1 | Toggle-mode pass was on an erase-suspended sector |
| erase_begun_o | output | 1 | Bit 3 of the latest status byte |

## Verification
The bench builds the block with MAX_POLLS set to 6 and a 12-bit address, and its read port answers two cycles after each request. With a limit this small, the read at which the operation completes and the read at which bit 5 rises can both be swept across every position up to and past the timeout limit, in both modes. The sweep includes the case where completion and bit 5 arrive in the same read. Sectors in erase suspend and start pulses during a running operation are also covered. A reference walk over the same generated status bytes gives the expected result, read count, suspend flag and window bit for every case.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    typedef enum logic [1:0] {
        RES_BUSY = 2'b00,
        RES_PASS = 2'b01,
        RES_FAIL = 2'b10,
        RES_TMO  = 2'b11
    } res_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_POLL,
        PH_RCHK_A,
        PH_RCHK_B
    } phase_e;

    localparam int unsigned BIT_DATA  = 7;
    localparam int unsigned BIT_TOG   = 6;
    localparam int unsigned BIT_LIMIT = 5;
    localparam int unsigned BIT_WIN   = 3;
    localparam int unsigned BIT_ALT   = 2;

endpackage

// File: rtl/fsp_word_eval.sv
module fsp_word_eval (
    input  logic       dq7_i,
    input  logic       dq6_i,
    input  logic       dq5_i,
    input  logic       dq2_i,
    input  logic [1:0] prev_i,      // {bit6, bit2} of the previous read
    input  logic       have_prev_i,
    input  logic       toggle_i,
    input  logic       exp7_i,
    output logic       settled_o,
    output logic       limit_o,
    output logic       alt_o
);
    logic tog_same;
    logic dat_same;

    always_comb begin
        tog_same  = have_prev_i && (dq6_i == prev_i[1]);
        dat_same  = (dq7_i == exp7_i);
        settled_o = toggle_i ? tog_same : dat_same;
        limit_o   = dq5_i;
        alt_o     = dq2_i ^ prev_i[0];
    end
endmodule

// File: rtl/fsp_poll_count.sv
module fsp_poll_count #(
    parameter int unsigned LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic step_i,
    output logic last_o
);
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)
            cnt_d = '0;
        else if (step_i)
            cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
    import fsp_pkg::*;
#(
    parameter int unsigned ADDR_W    = 22,
    parameter int unsigned MAX_POLLS = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic [7:0]        exp_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [7:0]        rd_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        result_o,
    output logic              suspended_o,
    output logic              erase_begun_o
);
    typedef struct packed {
        phase_e            phase;
        logic              mode;
        logic              exp7;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        prev;
        logic              have_prev;
        res_e              result;
        logic              susp;
        logic              win;
        logic              done;
    } st_t;

    st_t st_d, st_q;

    logic settled, limit, alt, last;
    logic cnt_clear, cnt_step;
    logic unused_bits;

    assign unused_bits = ^{rd_data_i[4], rd_data_i[1:0], exp_i[6:0]};

    fsp_word_eval u_eval (
        .dq7_i       (rd_data_i[BIT_DATA]),
        .dq6_i       (rd_data_i[BIT_TOG]),
        .dq5_i       (rd_data_i[BIT_LIMIT]),
        .dq2_i       (rd_data_i[BIT_ALT]),
        .prev_i      (st_q.prev),
        .have_prev_i (st_q.have_prev),
        .toggle_i    (st_q.mode),
        .exp7_i      (st_q.exp7),
        .settled_o   (settled),
        .limit_o     (limit),
        .alt_o       (alt)
    );

    fsp_poll_count #(.LIMIT(MAX_POLLS)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (cnt_clear),
        .step_i  (cnt_step),
        .last_o  (last)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        cnt_clear = 1'b0;
        cnt_step  = 1'b0;

        if (st_q.phase == PH_IDLE) begin
            if (start_i) begin
                st_d.phase     = PH_POLL;
                st_d.mode      = mode_i;
                st_d.exp7      = exp_i[BIT_DATA];
                st_d.addr      = addr_i;
                st_d.have_prev = 1'b0;
                st_d.result    = RES_BUSY;
                st_d.susp      = 1'b0;
                st_d.win       = 1'b0;
                cnt_clear      = 1'b1;
            end
        end else if (rd_ack_i) begin
            st_d.prev      = {rd_data_i[BIT_TOG], rd_data_i[BIT_ALT]};
            st_d.have_prev = 1'b1;
            st_d.win       = rd_data_i[BIT_WIN];

            unique case (st_q.phase)
                PH_POLL: begin
                    if (settled) begin
                        st_d.phase  = PH_IDLE;
                        st_d.result = RES_PASS;
                        st_d.susp   = st_q.mode & alt;
                        st_d.done   = 1'b1;
                    end else if (limit) begin
                        st_d.phase = PH_RCHK_A;
                    end else if (last) begin
                        st_d.phase  = PH_IDLE;
                        st_d.result = RES_TMO;
                        st_d.done   = 1'b1;
                    end else begin
                        cnt_step = 1'b1;
                    end
                end
                PH_RCHK_A: begin
                    if (!st_q.mode) begin
                        st_d.phase  = PH_IDLE;
                        st_d.result = settled ? RES_PASS : RES_FAIL;
                        st_d.done   = 1'b1;
                    end else begin
                        st_d.phase = PH_RCHK_B;
                    end
                end
                PH_RCHK_B: begin
                    st_d.phase  = PH_IDLE;
                    st_d.result = settled ? RES_PASS : RES_FAIL;
                    st_d.susp   = settled & alt;
                    st_d.done   = 1'b1;
                end
                default: st_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase     <= PH_IDLE;
            st_q.mode      <= 1'b0;
            st_q.exp7      <= 1'b0;
            st_q.addr      <= '0;
            st_q.prev      <= '0;
            st_q.have_prev <= 1'b0;
            st_q.result    <= RES_BUSY;
            st_q.susp      <= 1'b0;
            st_q.win       <= 1'b0;
            st_q.done      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_req_o      = (st_q.phase != PH_IDLE);
    assign busy_o        = (st_q.phase != PH_IDLE);
    assign rd_addr_o     = st_q.addr;
    assign done_o        = st_q.done;
    assign result_o      = st_q.result;
    assign suspended_o   = st_q.susp;
    assign erase_begun_o = st_q.win;
endmodule

// File: rtl/flash_status_poller_chk.sv
module flash_status_poller_chk #(
    parameter int unsigned ADDR_W    = 22,
    parameter int unsigned MAX_POLLS = 1024
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              mode_i,
    input logic              rd_req_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              rd_ack_i,
    input logic [7:0]        rd_data_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [1:0]        result_o,
    input logic              suspended_o
);
    logic seen5_q;
    logic mode_q;
    int   acks_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen5_q <= 1'b0;
            mode_q  <= 1'b0;
            acks_q  <= 0;
        end else if (start_i && !busy_o) begin
            seen5_q <= 1'b0;
            mode_q  <= mode_i;
            acks_q  <= 0;
        end else if (rd_ack_i && rd_req_o) begin
            acks_q <= acks_q + 1;
            if (rd_data_i[5]) seen5_q <= 1'b1;
        end
    end

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(rd_addr_o)); // R2
    AST_BUSY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (result_o == 2'b00)); // R2
    AST_FAIL_AFTER_DQ5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && result_o == 2'b10) |-> seen5_q); // R5
    AST_TIMEOUT_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && result_o == 2'b11) |-> (acks_q == int'(MAX_POLLS))); // R6
    AST_SUSP_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        suspended_o |-> (mode_q && result_o == 2'b01)); // R7
    AST_DONE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (result_o != 2'b00 && !busy_o && !rd_req_o)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(!busy_o)) |-> $stable(result_o)); // R9
endmodule

bind flash_status_poller flash_status_poller_chk #(
    .ADDR_W    (ADDR_W),
    .MAX_POLLS (MAX_POLLS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mode_i      (mode_i),
    .rd_req_o    (rd_req_o),
    .rd_addr_o   (rd_addr_o),
    .rd_ack_i    (rd_ack_i),
    .rd_data_i   (rd_data_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .result_o    (result_o),
    .suspended_o (suspended_o)
);

// File: tb/sim_flash_status_poller.sv
module sim_flash_status_poller;
    localparam int AW   = 12;
    localparam int MAXP = 6;
    localparam int LAT  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          mode = 1'b0;
    logic [7:0]    exp_b = 8'h00;
    logic [AW-1:0] addr = '0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          ack = 1'b0;
    logic [7:0]    rdat = 8'h00;
    logic          busy, done, susp, win;
    logic [1:0]    result;

    int checks = 0;
    int fails  = 0;

    logic          scn_mode = 1'b0;
    logic [7:0]    scn_exp = 8'h00;
    int            scn_done_at = 1;
    int            scn_dq5_at = 0;
    bit            scn_susp = 1'b0;
    logic [AW-1:0] scn_addr = '0;

    int nrd = 0;
    int lat = 0;
    int addr_err = 0;
    int done_cnt = 0;

    always #5 clk = ~clk;

    flash_status_poller #(.ADDR_W(AW), .MAX_POLLS(MAXP)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
        .exp_i(exp_b), .addr_i(addr), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
        .rd_ack_i(ack), .rd_data_i(rdat), .busy_o(busy), .done_o(done),
        .result_o(result), .suspended_o(susp), .erase_begun_o(win)
    );

    function automatic logic [7:0] gen_word(int n);
        logic b;
        b = scn_susp ? 1'b1 : (n < scn_done_at);
        if (!b) return scn_exp;
        return {~scn_exp[7], (scn_susp ? 1'b1 : n[0]),
                (scn_dq5_at != 0 && n >= scn_dq5_at), 1'b0,
                (n >= 2), n[0], 2'b01};
    endfunction

    // read port model: acknowledges LAT cycles after a request
    always @(posedge clk) begin
        if (start && !busy) nrd <= 0;
        if (ack) begin
            ack <= 1'b0;
            lat <= 0;
        end else if (rd_req) begin
            if (lat == LAT - 1) begin
                ack  <= 1'b1;
                rdat <= gen_word(nrd + 1);
                nrd  <= nrd + 1;
                if (rd_addr != scn_addr) addr_err <= addr_err + 1;
            end else begin
                lat <= lat + 1;
            end
        end
        if (done) done_cnt <= done_cnt + 1;
    end

    task automatic chk(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // reference walk over the generated status bytes, per the requirements
    task automatic ref_run(output int reads, output int res, output bit sp);
        int   cnt = 0;
        bit   hp = 0;
        bit   fin = 0;
        int   ph = 0;
        logic [1:0] pv = 2'b00;
        logic [7:0] w;
        bit   settled, alt;
        reads = 0; res = 0; sp = 0;
        while (!fin && reads < 1000) begin
            reads++;
            w = gen_word(reads);
            settled = scn_mode ? (hp && w[6] == pv[1]) : (w[7] == scn_exp[7]);
            alt = (w[2] != pv[0]);
            if (ph == 0) begin
                if (settled) begin fin = 1; res = 1; sp = scn_mode && alt; end
                else if (w[5]) ph = 1;
                else begin cnt++; if (cnt == MAXP) begin fin = 1; res = 3; end end
            end else if (ph == 1) begin
                if (!scn_mode) begin fin = 1; res = settled ? 1 : 2; end
                else ph = 2;
            end else begin
                fin = 1; res = settled ? 1 : 2; sp = settled && alt;
            end
            pv = {w[6], w[2]};
            hp = 1;
        end
    endtask

    task automatic run_case(bit m, logic [7:0] e, int da, int d5, bit sus,
                            logic [AW-1:0] a, bit disturb);
        int    r_reads, r_res, d0, a0, k;
        bit    r_sp;
        logic [7:0] lastw;
        string tag;
        scn_mode = m; scn_exp = e; scn_done_at = da; scn_dq5_at = d5;
        scn_susp = sus; scn_addr = a;
        ref_run(r_reads, r_res, r_sp);
        lastw = gen_word(r_reads);
        @(negedge clk);
        d0 = done_cnt; a0 = addr_err;
        start = 1'b1; mode = m; exp_b = e; addr = a;
        @(negedge clk);
        start = 1'b0;
        chk(busy && rd_req, "R2 busy after start", int'(busy), 1);
        chk(win == 1'b0, "R8 window cleared on start", int'(win), 0);
        chk(result == 2'b00, "R2 busy code", int'(result), 0);
        if (disturb) begin
            @(negedge clk);
            start = 1'b1; mode = ~m; exp_b = ~e; addr = ~a;
            @(negedge clk);
            start = 1'b0;
        end
        k = 0;
        while (!done && k < 3000) begin
            @(negedge clk);
            k++;
        end
        if (r_res == 1) tag = (d5 != 0 && d5 <= r_reads) ? "R5" : (m ? "R4" : "R3");
        else if (r_res == 2) tag = "R5";
        else tag = "R6";
        if (disturb) tag = "R10";
        chk(int'(result) == r_res, tag, int'(result), r_res);
        chk(nrd == r_reads, "R6 read count", nrd, r_reads);
        chk(susp == r_sp, "R7 suspended flag", int'(susp), int'(r_sp));
        chk(win == lastw[3], "R8 window bit", int'(win), int'(lastw[3]));
        chk(!busy && !rd_req, "R9 idle at done", int'(rd_req), 0);
        chk(addr_err == a0, "R2 read address", addr_err - a0, 0);
        repeat (3) @(negedge clk);
        chk(int'(result) == r_res, "R9 result held", int'(result), r_res);
        chk(done_cnt - d0 == 1, "R9 single done", done_cnt - d0, 1);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL R9 watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] pat [4];
        pat[0] = 8'h00; pat[1] = 8'hFF; pat[2] = 8'h80; pat[3] = 8'h7F;
        repeat (3) @(negedge clk);
        chk(!rd_req && !busy && !done && !susp && !win, "R1 reset outputs",
            int'({rd_req, busy, done, susp, win}), 0);
        chk(result == 2'b00, "R1 reset code", int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rd_req && !busy, "R1 idle after reset", int'(rd_req), 0);

        for (int m = 0; m < 2; m++)
            for (int da = 1; da <= 9; da++)
                for (int d5 = 0; d5 <= 9; d5++)
                    run_case(m[0], pat[(da + d5) % 4], da, d5, 1'b0,
                             AW'(da * 37 + d5 * 5 + m), 1'b0);

        for (int m = 0; m < 2; m++)
            for (int d5 = 0; d5 <= 4; d5++)
                run_case(m[0], 8'hFF, 1, d5, 1'b1, AW'(12'h3A0 + d5), 1'b0);

        // chip erase style: expected FFh, completion after a few reads
        run_case(1'b0, 8'hFF, 4, 0, 1'b0, AW'(12'h800), 1'b0);
        // start while busy is ignored
        run_case(1'b0, 8'h80, 5, 0, 1'b0, AW'(12'h155), 1'b1);
        run_case(1'b1, 8'h00, 9, 0, 1'b0, AW'(12'h2AA), 1'b1);
        run_case(1'b1, 8'hFF, 1, 0, 1'b1, AW'(12'h0F0), 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule